// File: doc/BRIEF.md
# Radix (−1+j) Complex-Binary Subtractor

This block subtracts one 32-bit complex-binary operand from another. In this number system, bit n has weight (−1+j)^n, so a single string holds a Gaussian integer. The block avoids the usual borrow-from-the-next-bit. Instead, it removes each place where the subtrahend has a 1 over a 0 in the minuend by rewriting the minuend:

- It adds one unit at position k.
- It adds one unit at each of positions k+2, k+3 and k+4. Together these three equal −2·(−1+j)^k.
- It clears the subtrahend bit.

The digits of the minuend that this rewrite produces are then brought back to 0/1 with the complex-binary carry rule: a two at position n becomes ones at n+2 and n+3.

A caller pulses `start_i` with both operands and then waits for `done_o`. When no 0−1 position is left, the difference is the minuend with the subtrahend's ones removed. The difference is held together with two flags until the next completion:
- an overflow flag, raised when any unit is pushed past the top bit;
- an error flag, raised when the step budget runs out.

Top module: `cbs_sub`

## Requirements
- R1: After reset, `done_o`, `ovf_o` and `err_o` are 0 and `diff_o` is 0.
- R2: A `start_i` pulse while idle captures `a_i` as minuend and `b_i` as subtrahend. A `start_i` while an operation runs is ignored and does not change that operation's result.
- R3: When `ovf_o` and `err_o` are both 0, the value of `diff_o` equals value(a) − value(b). Here value(v) is the sum of (−1+j)^n over every set bit n of v.
- R4: If no bit position has subtrahend 1 over minuend 0, `diff_o` = a AND NOT b. For example, b = 0 gives a, and a = b gives 0 with no overflow.
- R5: At a 0−1 position k, the minuend gains a unit at k, k+2, k+3 and k+4, position k+1 is untouched, and subtrahend bit k is cleared. The lowest such k is handled first. For example, a = 0 and b = 1 give exactly 0x1D.
- R6: A minuend digit of two at position n becomes 0 at n and adds a unit at n+2 and n+3. For example, a = 0x4 and b = 0x1 give exactly 0xE9.
- R7: Any unit placed above bit 31, by a rewrite or by a carry, sets `ovf_o` for that result. For example, b = 1<<27 with a = 0 gives no overflow and diff 0xE8000000, while b = 1<<28 overflows.
- R8: Each rewrite and each carry round costs one step. If work remains after MAX_STEPS steps (default 128), the operation ends with `err_o` = 1. With MAX_STEPS = 2, a = 0x4 and b = 0x1 end with `err_o` = 1, while a = 0 and b = 1 do not.
- R9: `done_o` is a single-cycle pulse for each accepted start. `diff_o`, `ovf_o` and `err_o` hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| a_i | input | 32 | Minuend, complex-binary |
| b_i | input | 32 | Subtrahend, complex-binary |
| diff_o | output | 32 | Difference, complex-binary |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | A unit was lost above bit 31 |
| err_o | output | 1 | Step budget exhausted before completion |

## Verification
The assertions take for granted that digits entering a rewrite are already 0/1. The control enforces this by giving carry rounds priority over rewrites.

They also rely on the subtrahend changing only at a start taken while idle. The stimulus therefore only ever pulses start for one cycle. It raises start mid-run only in the test that shows such a start is ignored.

Random operands are confined to the low 16 bits so that most runs finish without overflow and their complex values can be compared. Runs that overflow or hit the budget are not value-checked. Those two outcomes are instead driven by directed operands whose digit evolution is worked out by hand.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} cbs_state_e;
endpackage

// File: rtl/cbs_norm.sv
// One parallel carry round: a digit of two at n becomes units at n+2 and n+3.
module cbs_norm #(
  parameter int W = 32
) (
  input  logic [W-1:0][1:0] dig_i,
  output logic [W-1:0][1:0] dig_o,
  output logic              need_o,
  output logic              ovf_o
);
  logic [W-1:0] carry;

  for (genvar n = 0; n < W; n++) begin : g_carry
    assign carry[n] = dig_i[n][1];
  end

  for (genvar n = 0; n < W; n++) begin : g_dig
    if (n >= 3) begin : g_full
      assign dig_o[n] = {1'b0, dig_i[n][0]} + {1'b0, carry[n-2]} + {1'b0, carry[n-3]};
    end else if (n == 2) begin : g_two
      assign dig_o[n] = {1'b0, dig_i[n][0]} + {1'b0, carry[0]};
    end else begin : g_low
      assign dig_o[n] = {1'b0, dig_i[n][0]};
    end
  end

  assign need_o = |carry;
  // carries from the top three positions land at or above W
  assign ovf_o  = carry[W-1] | carry[W-2] | carry[W-3];
endmodule

// File: rtl/cbs_find.sv
// Lowest position with subtrahend 1 over minuend digit 0.
module cbs_find #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0][1:0] dig_i,
  input  logic [W-1:0]      b_i,
  output logic              found_o,
  output logic [IW-1:0]     idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (b_i[i] && dig_i[i] == 2'd0) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cbs_apply.sv
// Borrow rewrite: +1 at k, k+2, k+3, k+4 of the minuend; clear subtrahend bit k.
module cbs_apply #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0][1:0] dig_i,
  input  logic [W-1:0]      b_i,
  input  logic [IW-1:0]     idx_i,
  output logic [W-1:0][1:0] dig_o,
  output logic [W-1:0]      b_o,
  output logic              ovf_o
);
  int k;

  always_comb begin
    k = int'(idx_i);
    for (int n = 0; n < W; n++) begin
      dig_o[n] = dig_i[n] + 2'((n == k) || (n == k + 2) || (n == k + 3) || (n == k + 4));
      b_o[n]   = b_i[n] && (n != k);
    end
    ovf_o = (k + 4 >= W);
  end
endmodule

// File: rtl/cbs_sub.sv
module cbs_sub
  import cbs_pkg::*;
#(
  parameter int W         = 32,
  parameter int MAX_STEPS = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] diff_o,
  output logic         done_o,
  output logic         ovf_o,
  output logic         err_o
);
  localparam int IW = $clog2(W);
  localparam int CW = $clog2(MAX_STEPS + 1);

  cbs_state_e        st_q;
  logic [W-1:0][1:0] dig_q, dig_load, nrm_dig, app_dig;
  logic [W-1:0]      b_q, app_b, fin_diff;
  logic [CW-1:0]     cnt_q;
  logic              ovf_run_q, diff_ovf_q, err_q, done_q;
  logic [W-1:0]      diff_q;
  logic              nrm_need, nrm_ovf, fnd_found, app_ovf, at_limit;
  logic [IW-1:0]     fnd_idx;

  cbs_norm #(.W(W)) u_norm (
    .dig_i (dig_q),
    .dig_o (nrm_dig),
    .need_o(nrm_need),
    .ovf_o (nrm_ovf)
  );

  cbs_find #(.W(W), .IW(IW)) u_find (
    .dig_i  (dig_q),
    .b_i    (b_q),
    .found_o(fnd_found),
    .idx_o  (fnd_idx)
  );

  cbs_apply #(.W(W), .IW(IW)) u_apply (
    .dig_i(dig_q),
    .b_i  (b_q),
    .idx_i(fnd_idx),
    .dig_o(app_dig),
    .b_o  (app_b),
    .ovf_o(app_ovf)
  );

  always_comb begin
    for (int n = 0; n < W; n++) begin
      dig_load[n] = {1'b0, a_i[n]};
      fin_diff[n] = dig_q[n][0] & ~b_q[n];
    end
  end

  assign at_limit = (cnt_q == CW'(MAX_STEPS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      dig_q      <= '0;
      b_q        <= '0;
      cnt_q      <= '0;
      ovf_run_q  <= 1'b0;
      diff_q     <= '0;
      diff_ovf_q <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            dig_q     <= dig_load;
            b_q       <= b_i;
            cnt_q     <= '0;
            ovf_run_q <= 1'b0;
            st_q      <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!nrm_need && !fnd_found) begin
            diff_q     <= fin_diff;
            diff_ovf_q <= ovf_run_q;
            err_q      <= 1'b0;
            done_q     <= 1'b1;
            st_q       <= ST_IDLE;
          end else if (at_limit) begin
            diff_q     <= fin_diff;
            diff_ovf_q <= ovf_run_q;
            err_q      <= 1'b1;
            done_q     <= 1'b1;
            st_q       <= ST_IDLE;
          end else if (nrm_need) begin
            // carries first: rewrites assume 0/1 digits
            dig_q     <= nrm_dig;
            ovf_run_q <= ovf_run_q | nrm_ovf;
            cnt_q     <= cnt_q + 1'b1;
          end else begin
            dig_q     <= app_dig;
            b_q       <= app_b;
            ovf_run_q <= ovf_run_q | app_ovf;
            cnt_q     <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign diff_o = diff_q;
  assign done_o = done_q;
  assign ovf_o  = diff_ovf_q;
  assign err_o  = err_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_STEPS));

  // R5
  borrow_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !nrm_need && fnd_found && !at_limit)
      |=> (dig_q[$past(fnd_idx)] == 2'd1 && !b_q[$past(fnd_idx)]));

  // R2
  sub_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && $past(st_q) == ST_RUN) |-> $countones(b_q) <= $countones($past(b_q)));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && $past(st_q) == ST_RUN && $past(ovf_run_q)) |-> ovf_run_q);

  // R8
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
endmodule

// File: tb/tb_cbs_sub.sv
`timescale 1ns/1ps
module tb_cbs_sub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_m = 1'b0, st_l = 1'b0;
  logic [31:0] a_in = '0, b_in = '0;
  logic [31:0] d_m, d_l;
  logic        dn_m, dn_l, ov_m, ov_l, er_m, er_l;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  cbs_sub dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st_m), .a_i(a_in), .b_i(b_in),
    .diff_o(d_m), .done_o(dn_m), .ovf_o(ov_m), .err_o(er_m)
  );

  cbs_sub #(.MAX_STEPS(2)) dut_lim (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st_l), .a_i(a_in), .b_i(b_in),
    .diff_o(d_l), .done_o(dn_l), .ovf_o(ov_l), .err_o(er_l)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void cval(input logic [31:0] v, output longint re, output longint im);
    longint pr = 1, pi = 0, t;
    re = 0; im = 0;
    for (int n = 0; n < 32; n++) begin
      if (v[n]) begin re += pr; im += pi; end
      t  = -pr - pi;
      pi = pr - pi;
      pr = t;
    end
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit lim,
                        output logic [31:0] d, output logic o, output logic e, output bit got);
    @(negedge clk);
    a_in = a; b_in = b;
    if (lim) st_l = 1'b1; else st_m = 1'b1;
    @(negedge clk);
    st_l = 1'b0; st_m = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (lim ? dn_l : dn_m) begin got = 1'b1; break; end
      @(negedge clk);
    end
    d = lim ? d_l : d_m;
    o = lim ? ov_l : ov_m;
    e = lim ? er_l : er_m;
    if (!got) check(1'b0, "R9 no done", '0, 32'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(dn_m == 1'b0 && ov_m == 1'b0 && er_m == 1'b0, "R1 flags", {29'd0, dn_m, ov_m, er_m}, '0);
    check(d_m == '0, "R1 diff", d_m, '0);
  endtask

  task automatic t_plain;
    logic [31:0] d; logic o, e; bit g;
    run_op(32'h00C3_5A17, 32'h0, 1'b0, d, o, e, g);
    check(d == 32'h00C3_5A17 && !o, "R4 b=0", d, 32'h00C3_5A17);
    run_op(32'hF0F0_1234, 32'hF0F0_1234, 1'b0, d, o, e, g);
    check(d == 32'h0 && !o && !e, "R4 a=b", d, 32'h0);
    run_op(32'h0000_00FF, 32'h0000_0055, 1'b0, d, o, e, g);
    check(d == 32'h0000_00AA, "R4 mask", d, 32'h0000_00AA);
  endtask

  task automatic t_borrow;
    logic [31:0] d; logic o, e; bit g;
    run_op(32'h0, 32'h1, 1'b0, d, o, e, g);
    check(d == 32'h1D && !o, "R5 0-1", d, 32'h1D);
    run_op(32'h4, 32'h1, 1'b0, d, o, e, g);
    check(d == 32'hE9 && !o && !e, "R6 carry", d, 32'hE9);
  endtask

  task automatic t_ovf;
    logic [31:0] d; logic o, e; bit g;
    run_op(32'h0, 32'h0800_0000, 1'b0, d, o, e, g);
    check(!o, "R7 k=27 no ovf", {31'd0, o}, 32'd0);
    check(d == 32'hE800_0000, "R7 k=27 diff", d, 32'hE800_0000);
    run_op(32'h0, 32'h1000_0000, 1'b0, d, o, e, g);
    check(o, "R7 k=28 ovf", {31'd0, o}, 32'd1);
    run_op(32'h0, 32'h8000_0000, 1'b0, d, o, e, g);
    check(o, "R7 k=31 ovf", {31'd0, o}, 32'd1);
  endtask

  task automatic t_limit;
    logic [31:0] d; logic o, e; bit g;
    run_op(32'h4, 32'h1, 1'b1, d, o, e, g);
    check(e, "R8 limit hit", {31'd0, e}, 32'd1);
    run_op(32'h0, 32'h1, 1'b1, d, o, e, g);
    check(!e && d == 32'h1D, "R8 within limit", d, 32'h1D);
  endtask

  task automatic t_busy_start;
    bit got = 0;
    bit extra = 0;
    @(negedge clk);
    a_in = 32'h4; b_in = 32'h1; st_m = 1'b1;
    @(negedge clk);
    st_m = 1'b0;
    @(negedge clk);
    a_in = 32'h7; b_in = 32'h2; st_m = 1'b1;
    @(negedge clk);
    st_m = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (dn_m) begin got = 1; break; end
      @(negedge clk);
    end
    check(got && d_m == 32'hE9, "R2 busy start ignored", d_m, 32'hE9);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (dn_m) extra = 1;
    end
    check(!extra, "R9 single done", {31'd0, extra}, 32'd0);
    check(d_m == 32'hE9 && !ov_m, "R9 hold", d_m, 32'hE9);
  endtask

  task automatic t_random;
    logic [31:0] a, b, d; logic o, e; bit g;
    longint ar, ai, br, bi, dr, di;
    for (int i = 0; i < 40; i++) begin
      a = $urandom & 32'h0000_FFFF;
      b = $urandom & 32'h0000_FFFF;
      run_op(a, b, 1'b0, d, o, e, g);
      if (!o && !e) begin
        cval(a, ar, ai); cval(b, br, bi); cval(d, dr, di);
        total++;
        if (dr != ar - br || di != ai - bi) begin
          bad++;
          $display("FAIL R3 a=%h b=%h act=(%0d,%0d) exp=(%0d,%0d)", a, b, dr, di, ar - br, ai - bi);
        end
      end
      run_op(a, a, 1'b0, d, o, e, g);
      check(d == 32'h0 && !o, "R3 a=b zero", d, 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_plain;
    t_borrow;
    t_ovf;
    t_limit;
    t_busy_start;
    t_random;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule